// File: doc/BRIEF.md
# Periodic Compare-Match Timer Channel

This block is one 16-bit counting channel for a CPU-driven timer. Software programs a prescaler choice, a compare value and a starting count through a small byte-addressed register window, then sets the channel's run bit in a start/stop register that is shared with sibling channels. While running, the counter advances once per prescaled tick. When it reaches the compare value it raises a sticky match flag, and it can optionally return to zero on the following tick, which gives a periodic event every compare+1 ticks.

The match flag drives a level interrupt when its enable bit is set. Software clears the flag in two steps. First it reads the status register while the flag is set, which arms the clear. Then it writes status with bit 0 at zero. A write of one to that bit, or a write made before any arming read, leaves the flag alone. The register bus is a plain single-cycle port. Writes take effect on the clock edge that samples them. Read data is valid combinationally in the same cycle as the read request, and the bus has no back-pressure.

Top module: `tmr_chan_top`

## Requirements
- R1: After reset, every channel register and the shared start register read 0x00/0x0000, status reads 0xFE, the counter does not move and the interrupt output is low.
- R2: The offset map is as follows. With `bus_shared`=0, offsets 0, 1, 2 and 4 are 8-bit read/write registers on data bits 7:0: control, mode, I/O control and interrupt enable. Offset 5 is status. Offsets 6 and 8 are the 16-bit counter and compare registers, accessed as whole halfwords. Every other offset reads 0, and writes to it are ignored.
- R3: With `bus_shared`=1, an access hits the 8-bit shared start register. Bit RUN_BIT (default 0) runs the counter. Clearing that bit halts the counter, which then holds its value. The other bits are stored and read back, and they start nothing.
- R4: Control bits 1:0 select the tick rate: 00 gives /1, 01 gives /4, 10 gives /16 and 11 gives /64. Control bit 2 has no effect. The prescaler restarts from zero whenever the channel is stopped, so the first tick arrives on the div-th clock edge after the run bit is set.
- R5: On each tick the counter adds one, wrapping from 0xFFFF to 0x0000, unless the clear-on-match rule applies.
- R6: When control bits 7:5 equal 001, a tick taken while the counter equals compare loads 0, so the count period is compare+1 ticks.
- R7: Status bit 0 (the match flag) sets on the edge where a tick makes the counter equal to compare, in either clear mode.
- R8: A status read while the flag is set arms a clear. A later status write with bit 0 at 0 clears the flag and disarms. A write with bit 0 at 1, or any write while not armed, leaves the flag set. A match in the same cycle as a clear wins.
- R9: `irq_o` is high exactly while the flag is set and interrupt-enable bit 0 is 1.
- R10: A CPU write of the counter takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_shared | input | 1 | 1 = access the shared start register |
| bus_addr | input | 4 | Byte offset inside the channel window |
| bus_wdata | input | 16 | Write data (bits 7:0 for byte registers) |
| bus_rdata | output | 16 | Read data, zero when no read is requested |
| irq_o | output | 1 | Level compare-match interrupt |

## Verification
The bound checker watches several rules on every cycle: a stopped counter holds its value, a clear-on-match tick lands on zero, a tick that reaches compare sets the flag, the flag survives writes that must not clear it, the interrupt never rises without the flag, and the upper status bits always read as one. The exact tick counts of each prescaler setting, the wrap at 0xFFFF, the period with clear-on-match and the full read-then-write clear sequence depend on multi-cycle register programming. Only the bench's scenarios can show these, by stopping the counter and reading back exact values.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  localparam int OFF_CTRL = 0;
  localparam int OFF_MODE = 1;
  localparam int OFF_IOC  = 2;
  localparam int OFF_IEN  = 4;
  localparam int OFF_STAT = 5;
  localparam int OFF_CNT  = 6;
  localparam int OFF_CMP  = 8;

  localparam logic [2:0] CLR_ON_CMP = 3'b001;
  localparam logic [7:0] STAT_HI_ONES = 8'hFE;

  typedef struct packed {
    logic [2:0] clr_src;
    logic [1:0] edge_sel;
    logic [2:0] psc;
  } ctrl_t;
endpackage

// File: rtl/tmr_chan_prescale.sv
module tmr_chan_prescale #(
  parameter int PSC_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PSC_W-1:0] pre_q;
  logic [PSC_W-1:0] lim;

  always_comb begin
    case (sel)
      2'd0:    lim = PSC_W'(0);
      2'd1:    lim = PSC_W'(3);
      2'd2:    lim = PSC_W'(15);
      default: lim = PSC_W'(63);
    endcase
  end

  assign tick = run && (pre_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (!run)   pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr_chan_counter.sv
module tmr_chan_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clr_sel,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] cmp,
  output logic [W-1:0] cnt,
  output logic         match_set
);
  logic [W-1:0] nxt;

  assign nxt       = (clr_sel && (cnt == cmp)) ? '0 : cnt + 1'b1;
  assign match_set = tick && !wr_en && (nxt == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (wr_en) cnt <= wr_data;
    else if (tick)  cnt <= nxt;
  end
endmodule

// File: rtl/tmr_chan_status.sv
module tmr_chan_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic rd,
  input  logic wr,
  input  logic wbit0,
  output logic flag,
  output logic armed
);
  logic do_clr;

  assign do_clr = wr && armed && !wbit0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (set)         flag <= 1'b1;
      else if (do_clr) flag <= 1'b0;

      if (do_clr)          armed <= 1'b0;
      else if (rd && flag) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_chan_top.sv
module tmr_chan_top
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 4,
  parameter int START_W = 8,
  parameter int RUN_BIT = 0,
  parameter int PSC_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic              bus_shared,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq_o
);
  localparam int BYTE_W = 8;

  ctrl_t              ctrl_q;
  logic [BYTE_W-1:0]  mode_q, ioc_q, ien_q;
  logic [START_W-1:0] start_q;
  logic [CNT_W-1:0]   cmp_q;
  logic [CNT_W-1:0]   cnt;
  logic               wr_any, rd_any, loc;
  logic               run, tick, clr_sel, cnt_wr, match_set;
  logic               stat_rd, stat_wr, flag, armed;
  logic [BYTE_W-1:0]  stat_val;

  assign wr_any  = bus_en && bus_we;
  assign rd_any  = bus_en && !bus_we;
  assign loc     = !bus_shared;
  assign cnt_wr  = wr_any && loc && (bus_addr == ADDR_W'(OFF_CNT));
  assign stat_wr = wr_any && loc && (bus_addr == ADDR_W'(OFF_STAT));
  assign stat_rd = rd_any && loc && (bus_addr == ADDR_W'(OFF_STAT));
  assign run     = start_q[RUN_BIT];
  assign clr_sel = (ctrl_q.clr_src == CLR_ON_CMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      mode_q  <= '0;
      ioc_q   <= '0;
      ien_q   <= '0;
      cmp_q   <= '0;
      start_q <= '0;
    end else if (wr_any) begin
      if (bus_shared) begin
        start_q <= bus_wdata[START_W-1:0];
      end else begin
        case (int'(bus_addr))
          OFF_CTRL: ctrl_q <= ctrl_t'(bus_wdata[BYTE_W-1:0]);
          OFF_MODE: mode_q <= bus_wdata[BYTE_W-1:0];
          OFF_IOC:  ioc_q  <= bus_wdata[BYTE_W-1:0];
          OFF_IEN:  ien_q  <= bus_wdata[BYTE_W-1:0];
          OFF_CMP:  cmp_q  <= bus_wdata;
          default:  ;
        endcase
      end
    end
  end

  tmr_chan_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .sel  (ctrl_q.psc[1:0]),
    .tick (tick)
  );

  tmr_chan_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .clr_sel  (clr_sel),
    .wr_en    (cnt_wr),
    .wr_data  (bus_wdata),
    .cmp      (cmp_q),
    .cnt      (cnt),
    .match_set(match_set)
  );

  tmr_chan_status u_stat (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (match_set),
    .rd   (stat_rd),
    .wr   (stat_wr),
    .wbit0(bus_wdata[0]),
    .flag (flag),
    .armed(armed)
  );

  assign stat_val = STAT_HI_ONES | {{(BYTE_W-1){1'b0}}, flag};

  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      if (bus_shared) begin
        bus_rdata = CNT_W'(start_q);
      end else begin
        case (int'(bus_addr))
          OFF_CTRL: bus_rdata = CNT_W'(ctrl_q);
          OFF_MODE: bus_rdata = CNT_W'(mode_q);
          OFF_IOC:  bus_rdata = CNT_W'(ioc_q);
          OFF_IEN:  bus_rdata = CNT_W'(ien_q);
          OFF_STAT: bus_rdata = CNT_W'(stat_val);
          OFF_CNT:  bus_rdata = cnt;
          OFF_CMP:  bus_rdata = cmp_q;
          default:  bus_rdata = '0;
        endcase
      end
    end
  end

  assign irq_o = flag && ien_q[0];
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         tick,
  input logic         cnt_wr,
  input logic         clr_sel,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cmp,
  input logic         flag,
  input logic         armed,
  input logic         stat_wr,
  input logic         wbit0,
  input logic         stat_rd,
  input logic [W-1:0] rdata,
  input logic         irq
);
  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));

  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && clr_sel && (cnt == cmp)) |=> (cnt == '0));

  // R7
  match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && !clr_sel && (W'(cnt + 1'b1) == cmp)) |=> flag);

  // R8
  unarmed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !armed && stat_wr) |=> flag);

  // R8
  one_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && stat_wr && wbit0) |=> flag);

  // R9
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

  // R1
  stat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> (rdata[7:1] == 7'h7F));
endmodule

bind tmr_chan_top tmr_chan_chk #(.W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .run    (run),
  .tick   (tick),
  .cnt_wr (cnt_wr),
  .clr_sel(clr_sel),
  .cnt    (cnt),
  .cmp    (cmp_q),
  .flag   (flag),
  .armed  (armed),
  .stat_wr(stat_wr),
  .wbit0  (bus_wdata[0]),
  .stat_rd(stat_rd),
  .rdata  (bus_rdata),
  .irq    (irq_o)
);

// File: tb/sim_tmr_chan_top.sv
`timescale 1ns/1ps
module sim_tmr_chan_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0, bus_shared = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  tmr_chan_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_shared(bus_shared), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // monitor: pops an expected item for every read seen on the bus
  always @(negedge clk) begin
    if (bus_en && !bus_we) begin
      if (sb.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL unexpected read: got %h exp none", bus_rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        n_chk++;
        if (bus_rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s: got %h exp %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic sh, input int off, input logic [15:0] d);
    @(posedge clk); #2;
    bus_en = 1'b1; bus_we = 1'b1; bus_shared = sh;
    bus_addr = 4'(off); bus_wdata = d;
    @(posedge clk); #2;
    bus_en = 1'b0; bus_we = 1'b0; bus_shared = 1'b0;
  endtask

  task automatic rd(input logic sh, input int off, input logic [15:0] e, input string tag);
    item_t it;
    @(posedge clk); #2;
    bus_en = 1'b1; bus_we = 1'b0; bus_shared = sh; bus_addr = 4'(off);
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #2;
    bus_en = 1'b0; bus_shared = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    n_chk++;
    if (irq_o !== e) begin
      n_fail++;
      $display("FAIL %s: got %b exp %b", tag, irq_o, e);
    end
  endtask

  // run the counter for k+2 clock edges, then stop
  task automatic run_for(input int k);
    wr(1'b1, 0, 16'h0001);
    repeat (k) @(posedge clk);
    wr(1'b1, 0, 16'h0000);
  endtask

  task automatic psc_case(input logic [7:0] c, input int k, input logic [15:0] e, input string tag);
    wr(1'b0, 0, {8'h00, c});
    wr(1'b0, 6, 16'h0000);
    run_for(k);
    rd(1'b0, 6, e, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    rd(1'b0, 0, 16'h0000, "R1 ctrl");
    rd(1'b0, 1, 16'h0000, "R1 mode");
    rd(1'b0, 2, 16'h0000, "R1 ioc");
    rd(1'b0, 4, 16'h0000, "R1 ien");
    rd(1'b0, 5, 16'h00FE, "R1 status");
    rd(1'b0, 6, 16'h0000, "R1 counter");
    rd(1'b0, 8, 16'h0000, "R1 compare");
    rd(1'b1, 0, 16'h0000, "R1 start");
    chk_irq(1'b0, "R1 irq");

    // R2 register map
    wr(1'b0, 1, 16'h00A5); rd(1'b0, 1, 16'h00A5, "R2 mode");
    wr(1'b0, 2, 16'h003C); rd(1'b0, 2, 16'h003C, "R2 ioc");
    wr(1'b0, 0, 16'h0018); rd(1'b0, 0, 16'h0018, "R2 ctrl");
    wr(1'b0, 8, 16'hBEEF); rd(1'b0, 8, 16'hBEEF, "R2 compare");
    wr(1'b0, 6, 16'h1234); rd(1'b0, 6, 16'h1234, "R2 counter");
    wr(1'b0, 3, 16'h0077); rd(1'b0, 3, 16'h0000, "R2 unmapped");
    wr(1'b0, 6, 16'h0000);

    // R3 other start bits do not run the channel
    wr(1'b1, 0, 16'h00FE);
    repeat (20) @(posedge clk);
    rd(1'b1, 0, 16'h00FE, "R3 start readback");
    rd(1'b0, 6, 16'h0000, "R3 no run");
    wr(1'b1, 0, 16'h0000);

    // R4 prescaler encodings, no match reachable
    wr(1'b0, 8, 16'hFFFF);
    psc_case(8'h00, 8,   16'd10, "R4 div1");
    repeat (30) @(posedge clk);
    rd(1'b0, 6, 16'd10, "R3 stopped holds");
    psc_case(8'h01, 38,  16'd10, "R4 div4");
    psc_case(8'h02, 158, 16'd10, "R4 div16");
    psc_case(8'h03, 638, 16'd10, "R4 div64");
    psc_case(8'h04, 8,   16'd10, "R4 bit2 ignored");
    rd(1'b0, 5, 16'h00FE, "R7 no match yet");

    // R5 wrap, R7 flag at 0xFFFF
    wr(1'b0, 0, 16'h0000);
    wr(1'b0, 6, 16'hFFFE);
    run_for(0);
    rd(1'b0, 6, 16'h0000, "R5 wrap");
    rd(1'b0, 5, 16'h00FF, "R7 flag no-clear mode");
    wr(1'b0, 5, 16'h00FE);
    rd(1'b0, 5, 16'h00FE, "R8 cleared after read");

    // R6 clear-on-match period compare+1
    wr(1'b0, 4, 16'h0001);
    wr(1'b0, 0, 16'h0020);
    wr(1'b0, 8, 16'h0004);
    wr(1'b0, 6, 16'h0000);
    run_for(10);
    rd(1'b0, 6, 16'h0002, "R6 period");
    chk_irq(1'b1, "R7 R9 irq on flag");

    // R9 enable gating
    wr(1'b0, 4, 16'h0000);
    chk_irq(1'b0, "R9 disabled");
    wr(1'b0, 4, 16'h0001);
    chk_irq(1'b1, "R9 re-enabled");

    // R8 clear protocol
    wr(1'b0, 5, 16'h00FE);
    chk_irq(1'b1, "R8 unarmed write keeps");
    rd(1'b0, 5, 16'h00FF, "R8 status set");
    wr(1'b0, 5, 16'h00FF);
    chk_irq(1'b1, "R8 write one keeps");
    wr(1'b0, 5, 16'h00FE);
    chk_irq(1'b0, "R8 armed clear");
    rd(1'b0, 5, 16'h00FE, "R8 status clear");

    // R10 counter write beats tick
    wr(1'b0, 0, 16'h0000);
    wr(1'b0, 8, 16'hFFFF);
    wr(1'b1, 0, 16'h0001);
    wr(1'b0, 6, 16'h0100);
    wr(1'b1, 0, 16'h0000);
    rd(1'b0, 6, 16'h0102, "R10 write priority");

    @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule